// File: doc/BRIEF.md
# Link integrity warning transmit gater

This block owns the transmit-enable lines of a two-sided media converter, one for the copper side and one for the fiber side. When the receive link on one side drops, the block switches that side's transmitter off for a short slice of every long window. The far-end partner then sees its link indicator blink and learns that the converter has lost its input. If no side has a receive link, every transmitter stays off.

The warning behaviour is allowed by a four-level configuration strap. The strap is presented as a 2-bit code, captured once shortly after reset and then frozen. The same strap also yields one bit of the management address, which the block passes out. Two decoded configuration flags can also veto the behaviour: a permit flag and a flag saying that only one data rate is configured. Timing comes from an external tick, nominally one per millisecond. The window length, the blanking length, the strap sampling delay, the synchronizer depth and the port count are all parameters.

Top module: `liw_tx_gater`

## Requirements
- R1: While `rst` is high, every `tx_en_o` bit is 0 and `strap_addr_bit_o` is 0. Both stay so until the strap has been captured.
- R2: The strap code is captured on the tick that completes `SAMPLE_DELAY_TICKS` ticks after reset release. Before that, every transmit-enable is 0. Later changes of `strap_code_i` have no effect until the next reset.
- R3: The strap codes 2'b00, 2'b01, 2'b10 and 2'b11 (rising level order) give warning-allowed 0, 1, 1, 0 and address bit 0, 0, 1, 1.
- R4: The warning is active only when the strap allows it, `warn_cfg_en_i` is 1 and `single_speed_i` is 1. Otherwise a port with its link down keeps transmitting, unless every link is down.
- R5: With the warning active, a port whose link is down while another link is up has its transmit-enable at 0 for `BLANK_TICKS` consecutive ticks of every `PERIOD_TICKS`-tick window, and at 1 for the rest of the window. Ports whose link is up are never blanked.
- R6: The gating treats every port alike: port 1 is blanked the same way as port 0.
- R7: When every receive link is down, every transmit-enable is 0, whatever the configuration.
- R8: When a blanked port's link returns, its transmit-enable goes to 1 on the clock after the synchronized status rises, even inside a blanking slice. The window counter is not restarted: the next blanking slice still begins `PERIOD_TICKS` ticks after the previous one began.
- R9: A change on `link_up_i` reaches `tx_en_o` after three rising clock edges: `SYNC_STAGES` (2) synchronizer flops and one output flop.
- R10: The window counter advances only on cycles with `tick_i` high. While ticks stop, the transmit-enables hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_i | input | 1 | Timebase tick, one clock wide |
| link_up_i | input | NPORT | Receive link status per port, asynchronous (bit 0 copper, bit 1 fiber) |
| warn_cfg_en_i | input | 1 | Decoded configuration permit for the warning |
| single_speed_i | input | 1 | 1 when exactly one data rate is configured |
| strap_code_i | input | 2 | Four-level strap as a code, 2'b00 lowest level |
| tx_en_o | output | NPORT | Transmit enable per port |
| strap_addr_bit_o | output | 1 | Management address bit decoded from the captured strap |

## Verification
The bench builds the block with a 20-tick window, a 5-tick blanking slice and a 3-tick strap delay, and ticks on every clock. With these values a whole blanking window fits in a few dozen cycles. The duty cycle, the re-enable that cuts a slice short, and the unbroken window phase after a link returns can each be measured directly at the outputs. It also makes it cheap to reset once per strap code and to show that the window freezes while ticks stop.

// File: rtl/liw_pkg.sv
package liw_pkg;

   typedef enum logic [1:0] {
      STRAP_GND  = 2'b00,
      STRAP_LOW  = 2'b01,
      STRAP_HIGH = 2'b10,
      STRAP_VCC  = 2'b11
   } strap_lvl_e;

   typedef struct packed {
      logic warn_allow;
      logic addr_bit;
   } strap_dec_t;

   function automatic strap_dec_t decode_strap(input strap_lvl_e lvl);
      strap_dec_t d;
      unique case (lvl)
         STRAP_GND:  d = '{warn_allow: 1'b0, addr_bit: 1'b0};
         STRAP_LOW:  d = '{warn_allow: 1'b1, addr_bit: 1'b0};
         STRAP_HIGH: d = '{warn_allow: 1'b1, addr_bit: 1'b1};
         default:    d = '{warn_allow: 1'b0, addr_bit: 1'b1};
      endcase
      return d;
   endfunction

endpackage

// File: rtl/liw_sync.sv
module liw_sync #(
   parameter int WIDTH  = 2,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("liw_sync: STAGES must be at least 2");
   end

   for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      logic [STAGES-1:0] sr;
      always_ff @(posedge clk) begin
         if (rst) sr <= '0;
         else     sr <= {sr[STAGES-2:0], d_i[b]};
      end
      assign q_o[b] = sr[STAGES-1];
   end

endmodule

// File: rtl/liw_period_timer.sv
module liw_period_timer #(
   parameter int PERIOD_TICKS = 3800,
   parameter int BLANK_TICKS  = 425
) (
   input  logic clk,
   input  logic rst,
   input  logic tick_i,
   output logic blank_o
);

   localparam int PW = (PERIOD_TICKS > 2) ? $clog2(PERIOD_TICKS) : 1;
   localparam logic [PW-1:0] LAST_PHASE = PW'(PERIOD_TICKS - 1);
   localparam logic [PW-1:0] BLANK_END  = PW'(BLANK_TICKS);
   localparam bit POW2 = ((1 << PW) == PERIOD_TICKS);

   if (PERIOD_TICKS < 2) begin : g_bad_period
      $error("liw_period_timer: PERIOD_TICKS must be at least 2");
   end
   if (BLANK_TICKS < 1 || BLANK_TICKS >= PERIOD_TICKS) begin : g_bad_blank
      $error("liw_period_timer: BLANK_TICKS must lie in 1..PERIOD_TICKS-1");
   end

   logic [PW-1:0] phase;
   logic [PW-1:0] phase_nxt;

   if (POW2) begin : g_wrap_free
      assign phase_nxt = phase + 1'b1;
   end else begin : g_wrap_cmp
      assign phase_nxt = (phase == LAST_PHASE) ? '0 : phase + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (rst)         phase <= '0;
      else if (tick_i) phase <= phase_nxt;
   end

   assign blank_o = (phase < BLANK_END);

   a_r10_phase_frozen_without_tick: assert property (
      @(posedge clk) disable iff (rst) !tick_i |=> $stable(phase));

   a_r5_phase_in_window: assert property (
      @(posedge clk) disable iff (rst) tick_i |=> (phase <= LAST_PHASE));

endmodule

// File: rtl/liw_strap_latch.sv
module liw_strap_latch
   import liw_pkg::*;
#(
   parameter int SAMPLE_DELAY_TICKS = 4
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       tick_i,
   input  logic [1:0] code_i,
   output logic       sampled_o,
   output logic       warn_allow_o,
   output logic       addr_bit_o
);

   localparam int DW = $clog2(SAMPLE_DELAY_TICKS + 1);
   localparam logic [DW-1:0] LAST_CNT = DW'(SAMPLE_DELAY_TICKS - 1);

   if (SAMPLE_DELAY_TICKS < 1) begin : g_bad_delay
      $error("liw_strap_latch: SAMPLE_DELAY_TICKS must be at least 1");
   end

   logic [DW-1:0] cnt;
   logic          sampled_q;
   strap_lvl_e    code_q;
   strap_dec_t    dec;
   logic          strobe;

   assign strobe = tick_i & ~sampled_q & (cnt == LAST_CNT);

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt       <= '0;
         sampled_q <= 1'b0;
         code_q    <= STRAP_GND;
      end else begin
         if (tick_i && !sampled_q) cnt <= cnt + 1'b1;
         if (strobe) begin
            sampled_q <= 1'b1;
            code_q    <= strap_lvl_e'(code_i);
         end
      end
   end

   assign dec          = decode_strap(code_q);
   assign sampled_o    = sampled_q;
   assign warn_allow_o = sampled_q & dec.warn_allow;
   assign addr_bit_o   = sampled_q & dec.addr_bit;

   a_r2_strap_frozen: assert property (
      @(posedge clk) disable iff (rst) sampled_q |=> (sampled_q && $stable(code_q)));

endmodule

// File: rtl/liw_tx_gater.sv
module liw_tx_gater #(
   parameter int NPORT              = 2,
   parameter int PERIOD_TICKS       = 3800,
   parameter int BLANK_TICKS        = 425,
   parameter int SAMPLE_DELAY_TICKS = 4,
   parameter int SYNC_STAGES        = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             tick_i,
   input  logic [NPORT-1:0] link_up_i,
   input  logic             warn_cfg_en_i,
   input  logic             single_speed_i,
   input  logic [1:0]       strap_code_i,
   output logic [NPORT-1:0] tx_en_o,
   output logic             strap_addr_bit_o
);

   if (NPORT < 2) begin : g_bad_nport
      $error("liw_tx_gater: NPORT must be at least 2");
   end

   logic [NPORT-1:0] link_s;
   logic             sampled;
   logic             warn_allow;
   logic             blank;
   logic             warn_active;
   logic             all_down;

   liw_sync #(
      .WIDTH (NPORT),
      .STAGES(SYNC_STAGES)
   ) u_sync (
      .clk(clk),
      .rst(rst),
      .d_i(link_up_i),
      .q_o(link_s)
   );

   liw_strap_latch #(
      .SAMPLE_DELAY_TICKS(SAMPLE_DELAY_TICKS)
   ) u_strap (
      .clk         (clk),
      .rst         (rst),
      .tick_i      (tick_i),
      .code_i      (strap_code_i),
      .sampled_o   (sampled),
      .warn_allow_o(warn_allow),
      .addr_bit_o  (strap_addr_bit_o)
   );

   liw_period_timer #(
      .PERIOD_TICKS(PERIOD_TICKS),
      .BLANK_TICKS (BLANK_TICKS)
   ) u_timer (
      .clk    (clk),
      .rst    (rst),
      .tick_i (tick_i),
      .blank_o(blank)
   );

   assign warn_active = warn_allow & warn_cfg_en_i & single_speed_i;
   assign all_down    = ~|link_s;

   for (genvar p = 0; p < NPORT; p++) begin : g_port
      logic gate_off;
      assign gate_off = warn_active & ~link_s[p] & blank;

      always_ff @(posedge clk) begin
         if (rst) tx_en_o[p] <= 1'b0;
         else     tx_en_o[p] <= sampled & ~all_down & ~gate_off;
      end

      a_r8_live_port_transmits: assert property (
         @(posedge clk) disable iff (rst) (sampled && link_s[p]) |=> tx_en_o[p]);
   end

   a_r1_reset_quiet: assert property (
      @(posedge clk) rst |=> (tx_en_o == '0 && !strap_addr_bit_o));

   a_r7_all_down_silent: assert property (
      @(posedge clk) disable iff (rst) (link_s == '0) |=> (tx_en_o == '0));

   a_r4_inactive_no_gating: assert property (
      @(posedge clk) disable iff (rst)
      (sampled && !warn_active && link_s != '0) |=> (tx_en_o == '1));

   a_r2_silent_before_strobe: assert property (
      @(posedge clk) disable iff (rst) !sampled |=> (tx_en_o == '0));

endmodule

// File: tb/tb_liw_tx_gater.sv
module tb_liw_tx_gater;

   localparam int NPORT  = 2;
   localparam int PERIOD = 20;
   localparam int BLANK  = 5;
   localparam int SDELAY = 3;

   logic             clk = 1'b0;
   logic             rst = 1'b1;
   logic             tick_i = 1'b1;
   logic [NPORT-1:0] link_up_i = 2'b11;
   logic             warn_cfg_en_i = 1'b1;
   logic             single_speed_i = 1'b1;
   logic [1:0]       strap_code_i = 2'b10;
   logic [NPORT-1:0] tx_en_o;
   logic             strap_addr_bit_o;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   typedef struct {
      string      req;
      logic [1:0] tx;
      logic       addr;
   } exp_t;
   exp_t exp_q[$];

   always #5 clk = ~clk;

   liw_tx_gater #(
      .NPORT(NPORT), .PERIOD_TICKS(PERIOD), .BLANK_TICKS(BLANK),
      .SAMPLE_DELAY_TICKS(SDELAY), .SYNC_STAGES(2)
   ) dut (
      .clk(clk), .rst(rst), .tick_i(tick_i), .link_up_i(link_up_i),
      .warn_cfg_en_i(warn_cfg_en_i), .single_speed_i(single_speed_i),
      .strap_code_i(strap_code_i), .tx_en_o(tx_en_o),
      .strap_addr_bit_o(strap_addr_bit_o)
   );

   // scoreboard monitor: compares queued expectations at the falling edge
   always @(negedge clk) begin
      if (exp_q.size() > 0) begin
         exp_t e;
         e = exp_q.pop_front();
         n_tests++;
         if (tx_en_o !== e.tx || strap_addr_bit_o !== e.addr) begin
            n_fail++;
            $display("FAIL %s: actual tx=%b addr=%b expected tx=%b addr=%b",
                     e.req, tx_en_o, strap_addr_bit_o, e.tx, e.addr);
         end
      end
   end

   task automatic push_exp(input string req, input logic [1:0] tx, input logic addr);
      exp_t e;
      e.req = req; e.tx = tx; e.addr = addr;
      exp_q.push_back(e);
      @(negedge clk);
      wait (exp_q.size() == 0);
   endtask

   task automatic chk(input string req, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic settle(input int n);
      repeat (n) @(posedge clk);
   endtask

   task automatic measure(input int n, output int low0, output int low1,
                          output int run0, output int edges0);
      int cur = 0;
      logic prev;
      low0 = 0; low1 = 0; run0 = 0; edges0 = 0;
      prev = tx_en_o[0];
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (!tx_en_o[0]) begin
            low0++; cur++;
            if (cur > run0) run0 = cur;
         end else cur = 0;
         if (!tx_en_o[1]) low1++;
         if (tx_en_o[0] != prev) edges0++;
         prev = tx_en_o[0];
      end
   endtask

   task automatic do_reset(input logic [1:0] code);
      @(negedge clk);
      rst = 1'b1; strap_code_i = code; link_up_i = 2'b11;
      settle(2);
      push_exp("R1 reset", 2'b00, 1'b0);
      rst = 1'b0;
      settle(1);
      push_exp("R2 before strobe", 2'b00, 1'b0);
      settle(SDELAY + 3);
      push_exp("R3 after strobe", 2'b11, code[1]);
   endtask

   initial begin : watchdog
      #(200000 * 10);
      if (!done) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin : driver
      int l0, l1, r0, e0, k;
      logic hold;
      do_reset(2'b10);

      // R2: strap changes after capture are ignored
      @(negedge clk); strap_code_i = 2'b00;
      settle(3);
      push_exp("R2 strap frozen", 2'b11, 1'b1);

      // R5: port 0 down, blanking duty cycle
      link_up_i = 2'b10;
      settle(4);
      measure(2 * PERIOD, l0, l1, r0, e0);
      chk("R5 port0 low cycles", l0, 2 * BLANK);
      chk("R5 port0 longest low run", r0, BLANK);
      chk("R5 live port1 never low", l1, 0);
      chk("R2 gating still active with changed strap", (l0 > 0) ? 1 : 0, 1);

      // R9 / R8: early re-enable and unbroken window phase
      k = 0;
      while (tx_en_o[0] !== 1'b1 && k < 4 * PERIOD) begin @(negedge clk); k++; end
      while (tx_en_o[0] !== 1'b0 && k < 4 * PERIOD) begin @(negedge clk); k++; end
      link_up_i = 2'b11;
      settle(2); @(negedge clk);
      chk("R9 still low after two edges", tx_en_o[0], 0);
      @(negedge clk);
      chk("R8 re-enabled inside slice", tx_en_o[0], 1);
      link_up_i = 2'b10;
      k = 3;
      while (k < 3 * PERIOD) begin
         @(negedge clk); k++;
         if (tx_en_o[0] === 1'b0) break;
      end
      chk("R8 next slice one period later", k, PERIOD);

      // R6: port 1 down
      @(negedge clk); link_up_i = 2'b01;
      settle(4);
      measure(2 * PERIOD, l0, l1, r0, e0);
      chk("R6 port1 low cycles", l1, 2 * BLANK);
      chk("R6 live port0 never low", l0, 0);

      // R7: both down
      @(negedge clk); link_up_i = 2'b00;
      settle(4);
      push_exp("R7 all down", 2'b00, 1'b1);
      measure(PERIOD, l0, l1, r0, e0);
      chk("R7 port0 low whole window", l0, PERIOD);
      chk("R7 port1 low whole window", l1, PERIOD);

      // R4: configuration vetoes
      @(negedge clk); link_up_i = 2'b10; single_speed_i = 1'b0;
      settle(4);
      measure(2 * PERIOD, l0, l1, r0, e0);
      chk("R4 multi-speed disables gating", l0, 0);
      @(negedge clk); single_speed_i = 1'b1; warn_cfg_en_i = 1'b0;
      settle(4);
      measure(2 * PERIOD, l0, l1, r0, e0);
      chk("R4 permit flag disables gating", l0, 0);
      @(negedge clk); warn_cfg_en_i = 1'b1;

      // R10: ticks stopped freeze the window
      settle(4);
      @(negedge clk); tick_i = 1'b0;
      settle(2);
      hold = tx_en_o[0];
      measure(3 * PERIOD, l0, l1, r0, e0);
      chk("R10 no toggles without tick", e0, 0);
      chk("R10 level held without tick", tx_en_o[0], hold);
      @(negedge clk); tick_i = 1'b1;
      settle(2);
      measure(2 * PERIOD, l0, l1, r0, e0);
      chk("R10 blanking resumes with tick", l0, 2 * BLANK);

      // R3: remaining strap codes
      for (int c = 0; c < 4; c++) begin
         if (c == 2) continue;
         do_reset(2'(c));
         @(negedge clk); link_up_i = 2'b10;
         settle(4);
         measure(2 * PERIOD, l0, l1, r0, e0);
         chk($sformatf("R3 code %0d gating", c), l0, (c == 1) ? 2 * BLANK : 0);
      end

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule